// File: doc/BRIEF.md
# Sixteen-Bit Ripple-Sliced Arithmetic and Logic Unit

This block computes one of six operations on two 16-bit operands: add, subtract, bitwise AND, bitwise OR, and a one-place logical shift in either direction. Addition, subtraction and the two logic functions come from four identical 4-bit function-table slices. The slices are chained by their carries, and every slice receives the same mode and select code. A 3-bit operation code is decoded into that shared mode and select code and into the carry fed to the lowest slice. The slices cannot move bits between positions, so a separate shifter produces the shift results, and a multiplexer chooses between the shifter and the slice chain.

The unit sits in a datapath that presents an operation code and two operands each cycle. On the next rising clock edge it captures the result, a carry flag, a zero flag and a signed-overflow flag in output registers. A synchronous active-high reset clears these registers.

Top module: `alu16_casc`

## Requirements
- R1: Operation code 000 (add) gives res_o = (a_i + b_i) mod 65536, and carry_o is bit 16 of the unsigned sum.
- R2: Operation code 001 (subtract) gives res_o = (a_i - b_i) mod 65536, and carry_o = 1 exactly when a_i >= b_i as unsigned numbers, meaning no borrow.
- R3: Operation code 010 gives a_i AND b_i and code 011 gives a_i OR b_i, both with carry_o = 0. For example, 0x0555 OR 0x0AAA = 0x0FFF.
- R4: Operation code 100 gives {a_i[14:0], 0} with carry_o = a_i[15]. The value of b_i has no effect on any output.
- R5: Operation code 101 gives {0, a_i[15:1]} with carry_o = a_i[0]. The value of b_i has no effect on any output.
- R6: Operation codes 110 and 111 give res_o = 0, carry_o = 0 and ovf_o = 0.
- R7: zero_o is 1 exactly when all 16 bits of res_o are 0.
- R8: ovf_o is 1 for an add whose operands share a sign that differs from the result's sign, and for a subtract whose operands differ in sign while the result's sign differs from a_i[15]. For every other operation code ovf_o is 0.
- R9: Carries ripple across all four slice boundaries. For example, 0x0FFF + 0x0001 = 0x1000, and 0xFFFF + 0x0001 gives 0x0000 with carry_o = 1.
- R10: All outputs are registered and reflect the inputs present at the previous rising clock edge. While rst is high at an edge, the outputs become res_o = 0, carry_o = 0, ovf_o = 0 and zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| res_o | output | 16 | Registered result |
| carry_o | output | 1 | Carry, no-borrow, or shifted-out bit |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
All four outputs are due exactly one rising edge after the operands and the operation code are applied, because one register stage follows the combinational slices and shifter. The bench changes inputs on the falling edge, lets one rising edge capture them, and samples on the following falling edge, so each sample sees the operation that was just captured. Reset is checked the same way: the reset value is read on the falling edge after the rising edge at which rst was high.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101,
    OP_NA6 = 3'b110,
    OP_NA7 = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    CL_ARITH = 2'd0,
    CL_LOGIC = 2'd1,
    CL_SHIFT = 2'd2,
    CL_NONE  = 2'd3
  } cls_e;
endpackage

// File: rtl/alu16_decode.sv
`timescale 1ns/1ps
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [2:0] op_i,
  output logic       mode_o,
  output logic [3:0] sel_o,
  output logic       cin_n_o,
  output cls_e       cls_o
);
  always_comb begin
    mode_o  = 1'b1;
    sel_o   = 4'b0000;
    cin_n_o = 1'b1;
    cls_o   = CL_NONE;
    case (op_e'(op_i))
      OP_ADD: begin mode_o = 1'b0; sel_o = 4'b1001; cin_n_o = 1'b1; cls_o = CL_ARITH; end
      OP_SUB: begin mode_o = 1'b0; sel_o = 4'b0110; cin_n_o = 1'b0; cls_o = CL_ARITH; end
      OP_AND: begin mode_o = 1'b1; sel_o = 4'b1011; cls_o = CL_LOGIC; end
      OP_OR:  begin mode_o = 1'b1; sel_o = 4'b1110; cls_o = CL_LOGIC; end
      OP_SHL, OP_SHR: cls_o = CL_SHIFT;
      default: cls_o = CL_NONE;
    endcase
  end
endmodule

// File: rtl/alu16_slice.sv
`timescale 1ns/1ps
// One function-table slice. Carry in and carry out are active low.
module alu16_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          mode_i,
  input  logic [3:0]    sel_i,
  input  logic          cn_n_i,
  output logic [SW-1:0] f_o,
  output logic          cout_n_o
);
  logic [SW-1:0] or_term;
  logic [SW-1:0] and_term;
  logic [SW:0]   sum;

  always_comb begin
    or_term  = a_i | ({SW{sel_i[0]}} & b_i) | ({SW{sel_i[1]}} & ~b_i);
    and_term = ({SW{sel_i[2]}} & a_i & ~b_i) | ({SW{sel_i[3]}} & a_i & b_i);
    sum      = {1'b0, or_term} + {1'b0, and_term} + {{SW{1'b0}}, ~cn_n_i};
    if (mode_i) begin
      f_o      = ~or_term ^ and_term;
      cout_n_o = 1'b1;
    end else begin
      f_o      = sum[SW-1:0];
      cout_n_o = ~sum[SW];
    end
  end
endmodule

// File: rtl/alu16_shift.sv
`timescale 1ns/1ps
module alu16_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         left_i,
  output logic [W-1:0] y_o,
  output logic         out_bit_o
);
  always_comb begin
    if (left_i) begin
      y_o       = {a_i[W-2:0], 1'b0};
      out_bit_o = a_i[W-1];
    end else begin
      y_o       = {1'b0, a_i[W-1:1]};
      out_bit_o = a_i[0];
    end
  end
endmodule

// File: rtl/alu16_casc.sv
`timescale 1ns/1ps
module alu16_casc
  import alu16_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  op_i,
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  output logic [15:0] res_o,
  output logic        carry_o,
  output logic        zero_o,
  output logic        ovf_o
);
  localparam int W = SLICE_W * NUM_SLICES;

  logic            mode;
  logic [3:0]      sel;
  logic            cin_n;
  cls_e            cls;
  logic [NUM_SLICES:0] cn_n;
  logic [W-1:0]    slice_f;
  logic [W-1:0]    sh_y;
  logic            sh_bit;
  logic [W-1:0]    nxt_res;
  logic            nxt_c;
  logic            nxt_v;

  alu16_decode u_dec (
    .op_i    (op_i),
    .mode_o  (mode),
    .sel_o   (sel),
    .cin_n_o (cin_n),
    .cls_o   (cls)
  );

  assign cn_n[0] = cin_n;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    alu16_slice #(.SW(SLICE_W)) u_sl (
      .a_i      (a_i[g*SLICE_W +: SLICE_W]),
      .b_i      (b_i[g*SLICE_W +: SLICE_W]),
      .mode_i   (mode),
      .sel_i    (sel),
      .cn_n_i   (cn_n[g]),
      .f_o      (slice_f[g*SLICE_W +: SLICE_W]),
      .cout_n_o (cn_n[g+1])
    );
  end

  alu16_shift #(.W(W)) u_sh (
    .a_i       (a_i),
    .left_i    (op_i == OP_SHL),
    .y_o       (sh_y),
    .out_bit_o (sh_bit)
  );

  always_comb begin
    nxt_res = '0;
    nxt_c   = 1'b0;
    nxt_v   = 1'b0;
    case (cls)
      CL_ARITH: begin
        nxt_res = slice_f;
        nxt_c   = ~cn_n[NUM_SLICES];
        if (op_i[0])
          nxt_v = (a_i[W-1] != b_i[W-1]) && (slice_f[W-1] != a_i[W-1]);
        else
          nxt_v = (a_i[W-1] == b_i[W-1]) && (slice_f[W-1] != a_i[W-1]);
      end
      CL_LOGIC: nxt_res = slice_f;
      CL_SHIFT: begin
        nxt_res = sh_y;
        nxt_c   = sh_bit;
      end
      default: nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
      zero_o  <= 1'b1;
      ovf_o   <= 1'b0;
    end else begin
      res_o   <= nxt_res;
      carry_o <= nxt_c;
      zero_o  <= (nxt_res == '0);
      ovf_o   <= nxt_v;
    end
  end

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 3'b000) |-> ({carry_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}))); // R1
  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 3'b001) |-> (res_o == $past(a_i) - $past(b_i) && carry_o == ($past(a_i) >= $past(b_i)))); // R2
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 3'b100) |-> (res_o == {$past(a_i[W-2:0]), 1'b0} && carry_o == $past(a_i[W-1]))); // R4
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 3'b101) |-> (res_o == {1'b0, $past(a_i[W-1:1])} && carry_o == $past(a_i[0]))); // R5
  AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i[2:1]) == 2'b11) |-> (res_o == '0 && !carry_o && !ovf_o)); // R6
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0)); // R7
  AST_OVF_ARITH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i[2:1]) != 2'b00) |-> !ovf_o); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && !carry_o && zero_o && !ovf_o)); // R10
endmodule

// File: tb/sim_alu16_casc.sv
`timescale 1ns/1ps
module sim_alu16_casc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op  = 3'd0;
  logic [15:0] a   = 16'h0;
  logic [15:0] b   = 16'h0;
  logic [15:0] res;
  logic        carry, zero, ovf;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu16_casc u0 (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
    .res_o(res), .carry_o(carry), .zero_o(zero), .ovf_o(ovf)
  );

  // {op, a, b, expected result}
  localparam int NV = 18;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 16'h0001, 16'h0001, 16'h0002},
    {3'd0, 16'hFFFF, 16'h0001, 16'h0000},
    {3'd0, 16'h7FFF, 16'h0001, 16'h8000},
    {3'd0, 16'h8000, 16'h8000, 16'h0000},
    {3'd0, 16'h0FFF, 16'h0001, 16'h1000},
    {3'd1, 16'h0005, 16'h0003, 16'h0002},
    {3'd1, 16'h0000, 16'h0001, 16'hFFFF},
    {3'd1, 16'h8000, 16'h0001, 16'h7FFF},
    {3'd1, 16'h1234, 16'h1234, 16'h0000},
    {3'd2, 16'hF0F0, 16'h0FF0, 16'h00F0},
    {3'd3, 16'h0555, 16'h0AAA, 16'h0FFF},
    {3'd2, 16'hFFFF, 16'h0000, 16'h0000},
    {3'd4, 16'h8001, 16'h1234, 16'h0002},
    {3'd4, 16'h7FFF, 16'h0000, 16'hFFFE},
    {3'd5, 16'h0001, 16'hFFFF, 16'h0000},
    {3'd5, 16'h8000, 16'h0000, 16'h4000},
    {3'd6, 16'h1234, 16'h5678, 16'h0000},
    {3'd7, 16'hFFFF, 16'hFFFF, 16'h0000}
  };

  // Returns {ovf, zero, carry, result} from the requirement text.
  function automatic logic [18:0] model(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
    logic [16:0] s;
    logic [15:0] r;
    logic c, v;
    r = 16'h0; c = 1'b0; v = 1'b0;
    case (o)
      3'd0: begin s = {1'b0, x} + {1'b0, y}; r = s[15:0]; c = s[16];
                  v = (x[15] == y[15]) && (r[15] != x[15]); end
      3'd1: begin r = x - y; c = (x >= y);
                  v = (x[15] != y[15]) && (r[15] != x[15]); end
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: begin r = {x[14:0], 1'b0}; c = x[15]; end
      3'd5: begin r = {1'b0, x[15:1]}; c = x[0]; end
      default: r = 16'h0;
    endcase
    return {v, (r == 16'h0), c, r};
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%05h exp=%05h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [18:0] r4a;
    repeat (3) @(negedge clk);
    check("R10 reset", {ovf, zero, carry, res}, {1'b0, 1'b1, 1'b0, 16'h0});
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]);
      // entry 4 exercises the ripple chain (R9)
      check({tag_of(VEC[i][50:48]), (i == 4 || i == 1) ? " R9 table" : " table"},
            {3'b000, res}, {3'b000, VEC[i][15:0]});
      check({tag_of(VEC[i][50:48]), " R7 R8 flags"}, {ovf, zero, carry, res},
            model(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]));
    end

    // R4 and R5: b has no effect on any output
    apply(3'd4, 16'hA5C3, 16'h0000);
    r4a = {ovf, zero, carry, res};
    apply(3'd4, 16'hA5C3, 16'hFFFF);
    check("R4 b ignored", {ovf, zero, carry, res}, r4a);
    apply(3'd5, 16'h5A3C, 16'h0000);
    r4a = {ovf, zero, carry, res};
    apply(3'd5, 16'h5A3C, 16'hFFFF);
    check("R5 b ignored", {ovf, zero, carry, res}, r4a);

    // Edge operands across every operation code
    for (int o = 0; o < 8; o++) begin
      for (int ia = 0; ia < 4; ia++) begin
        for (int ib = 0; ib < 4; ib++) begin
          logic [15:0] ea, eb;
          ea = (ia == 0) ? 16'h0000 : (ia == 1) ? 16'hFFFF : (ia == 2) ? 16'h8000 : 16'h7FFF;
          eb = (ib == 0) ? 16'h0000 : (ib == 1) ? 16'hFFFF : (ib == 2) ? 16'h8000 : 16'h7FFF;
          apply(3'(o), ea, eb);
          check({tag_of(3'(o)), " R8 edge"}, {ovf, zero, carry, res}, model(3'(o), ea, eb));
        end
      end
    end

    // Pseudo-random operands
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ra, rb;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ra = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rb = lf;
      apply(3'(k % 8), ra, rb);
      check({tag_of(3'(k % 8)), " R7 random"}, {ovf, zero, carry, res}, model(3'(k % 8), ra, rb));
    end

    // R10: reset clears a non-zero result
    apply(3'd0, 16'h7FFF, 16'h7FFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset after op", {ovf, zero, carry, res}, {1'b0, 1'b1, 1'b0, 16'h0});
    rst = 1'b0;
    apply(3'd1, 16'h0003, 16'h0005);
    check("R2 after reset", {ovf, zero, carry, res}, model(3'd1, 16'h0003, 16'h0005));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule